// File: doc/BRIEF.md
# DMA Channel Trigger and Destination Sequencer

This block runs one DMA channel. Software sets up a start destination, a transfer count, a transfer size, a destination stepping rule, a 4-bit trigger code and a mode bit that selects normal or block operation. It then raises the enable input. From that point the channel waits for the trigger that the code selects. Each accepted trigger produces one transfer in normal mode, or a burst of `blk_len` transfers in block mode. After each transfer the destination address is stepped.

The trigger can be the external request pin, which is active low and passes through a two-flop synchronizer before use. It can be one of eleven peripheral request lines, or a self-generated auto-request. The auto-request either gives up the bus for a cycle after each transfer (cycle steal) or keeps it until the end (burst). When the last counted transfer is done, the channel drops `busy` and pulses `done` for one cycle. It then ignores every trigger until it is armed again.

The controller is a five-state machine:
- IDLE: not busy.
- WAIT: armed and looking for a trigger.
- XFER: one transfer strobe per cycle.
- GAP: the idle bus cycle of cycle-steal mode.
- FIN: the completion pulse.

Its transitions are:
- IDLE→WAIT on arm.
- WAIT→IDLE on abort.
- WAIT→XFER on trigger.
- XFER→XFER while a block or a burst continues.
- XFER→GAP in cycle steal.
- XFER→WAIT when another trigger is needed.
- XFER→FIN on the last transfer.
- GAP→XFER.
- FIN→IDLE.

Top module: `dma_chan_ctrl`

## Requirements
- R1: After reset `busy`, `done` and `xfer_stb` are low and `dst_addr` is 0.
- R2: A rising edge of `en` seen in IDLE with nonzero `xfer_count` latches all controls and makes `busy` high and `dst_addr` equal to `start_addr` one cycle later. With a zero count the channel stays idle.
- R3: `dst_ctl` = 00 or 01 keeps the address fixed, 10 adds the step after each transfer and 11 subtracts it. The step is 1 when `word_size`=0 and 2 when it is 1. The address wraps modulo 2^24 in both directions.
- R4: In normal mode (`blk_mode`=0) the factor codes are 0010 falling-edge request, 0011 low-level request, 0110 cycle-steal auto-request and 0111 burst auto-request. All other codes are reserved.
- R5: In edge mode each falling edge of `dreq_n` (after synchronization) starts exactly one trigger. A pin held low starts nothing more. An edge that arrives during a transfer is kept until the channel waits again.
- R6: In level mode a synchronized low on `dreq_n` starts a trigger every time the channel is back in WAIT. In normal mode this gives one strobe every other cycle.
- R7: Cycle steal leaves at least one cycle without a strobe after each transfer. Burst gives strobes on consecutive cycles until the count is used up.
- R8: In block mode the codes are 0001 ADC end (`periph_req[0]`), 0010 edge, 0011 level, 0100/0101 serial 0/1 transmit done (`periph_req[1]`/`[2]`), 0110/0111 serial 0/1 receive done (`[3]`/`[4]`) and 1000–1101 timer 0–5 capture A (`[5]`–`[10]`). Codes 0000, 1110 and 1111 are reserved. Each trigger gives `blk_len` back-to-back strobes, with a length of 0 acting as 1. Other request lines have no effect.
- R9: The count drops by one per strobe. On the last strobe the channel goes through a single cycle with `done` high and `busy` low, then ignores all triggers.
- R10: Reserved codes never produce a strobe. Lowering `en` while in WAIT returns the channel to IDLE with no `done` pulse.
- R11: `xfer_word` shows the transfer size latched at arm.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| en | input | 1 | Channel enable; its rising edge arms the channel, its low level aborts a wait |
| blk_mode | input | 1 | 1 selects block mode, 0 selects normal mode |
| factor | input | 4 | Trigger code |
| word_size | input | 1 | 0 for byte transfers, 1 for word transfers |
| dst_ctl | input | 2 | Destination stepping rule |
| start_addr | input | 24 | Initial destination address |
| xfer_count | input | 16 | Number of transfers |
| blk_len | input | 8 | Transfers per trigger in block mode |
| dreq_n | input | 1 | External request pin, active low, asynchronous |
| periph_req | input | 11 | Peripheral request lines, active high |
| xfer_stb | output | 1 | One transfer takes place in this cycle |
| xfer_word | output | 1 | Size of the current transfer |
| dst_addr | output | 24 | Destination address of the current transfer |
| busy | output | 1 | Channel armed or transferring |
| done | output | 1 | One-cycle completion pulse |

## Verification
The hardest case to reach is a count that runs out in the middle of a block, where the last strobe must end in FIN and not fall back to WAIT. The stimulus reaches it by holding the request pin low in block level mode with a block length of 3 and a count of 4. A second hard case is an edge request during an active wait while the pin is still low from the previous edge. The bench raises and lowers the pin again between triggers and checks that a pin held low starts nothing further.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WAIT,
        ST_XFER,
        ST_GAP,
        ST_FIN
    } chan_state_t;

    // normal-mode trigger codes
    localparam logic [3:0] NRM_EDGE  = 4'b0010;
    localparam logic [3:0] NRM_LEVEL = 4'b0011;
    localparam logic [3:0] NRM_STEAL = 4'b0110;
    localparam logic [3:0] NRM_BURST = 4'b0111;

    // block-mode trigger codes
    localparam logic [3:0] BLK_ADC     = 4'b0001;
    localparam logic [3:0] BLK_EDGE    = 4'b0010;
    localparam logic [3:0] BLK_LEVEL   = 4'b0011;
    localparam logic [3:0] BLK_PERBASE = 4'b0011; // code minus this = line index

endpackage

// File: rtl/dma_trig_sel.sv
module dma_trig_sel
    import dma_chan_pkg::*;
#(
    parameter int NPER = 11
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            dreq_n,
    input  logic [NPER-1:0] periph_req,
    input  logic            blk_mode,
    input  logic [3:0]      factor,
    input  logic            arm,
    input  logic            take,
    output logic            trig,
    output logic            is_steal,
    output logic            is_burst,
    output logic            is_rsvd
);
    logic s1, s2, s3, pend, fall;
    logic [3:0] pidx;

    // two-flop synchronizer plus a history flop for edge detection
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1 <= 1'b1;
            s2 <= 1'b1;
            s3 <= 1'b1;
        end else begin
            s1 <= dreq_n;
            s2 <= s1;
            s3 <= s2;
        end
    end

    assign fall = s3 & ~s2;

    // edge memory: an edge seen while transferring is served at the next wait
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    pend <= 1'b0;
        else if (arm)  pend <= 1'b0;
        else if (take) pend <= pend & fall;
        else           pend <= pend | fall;
    end

    assign pidx = factor - BLK_PERBASE;

    always_comb begin
        trig     = 1'b0;
        is_steal = 1'b0;
        is_burst = 1'b0;
        is_rsvd  = 1'b0;
        if (!blk_mode) begin
            unique case (factor)
                NRM_EDGE:  trig = fall | pend;
                NRM_LEVEL: trig = ~s2;
                NRM_STEAL: begin trig = 1'b1; is_steal = 1'b1; end
                NRM_BURST: begin trig = 1'b1; is_burst = 1'b1; end
                default:   is_rsvd = 1'b1;
            endcase
        end else begin
            if (factor == BLK_ADC)        trig = periph_req[0];
            else if (factor == BLK_EDGE)  trig = fall | pend;
            else if (factor == BLK_LEVEL) trig = ~s2;
            else if (factor > BLK_LEVEL && int'(pidx) < NPER)
                trig = periph_req[pidx];
            else
                is_rsvd = 1'b1;
        end
    end

endmodule

// File: rtl/dma_addr_step.sv
module dma_addr_step #(
    parameter int AW = 24
) (
    input  logic [AW-1:0] cur,
    input  logic [1:0]    ctl,
    input  logic          word,
    output logic [AW-1:0] nxt
);
    logic [AW-1:0] step;

    assign step = word ? AW'(2) : AW'(1);

    always_comb begin
        if (!ctl[1])     nxt = cur;
        else if (ctl[0]) nxt = cur - step;
        else             nxt = cur + step;
    end

endmodule

// File: rtl/dma_chan_ctrl.sv
module dma_chan_ctrl
    import dma_chan_pkg::*;
#(
    parameter int AW   = 24,
    parameter int CW   = 16,
    parameter int BW   = 8,
    parameter int NPER = 11
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            en,
    input  logic            blk_mode,
    input  logic [3:0]      factor,
    input  logic            word_size,
    input  logic [1:0]      dst_ctl,
    input  logic [AW-1:0]   start_addr,
    input  logic [CW-1:0]   xfer_count,
    input  logic [BW-1:0]   blk_len,
    input  logic            dreq_n,
    input  logic [NPER-1:0] periph_req,
    output logic            xfer_stb,
    output logic            xfer_word,
    output logic [AW-1:0]   dst_addr,
    output logic            busy,
    output logic            done
);
    chan_state_t state, state_nx;

    logic          en_q, arm, take, last;
    logic [AW-1:0] addr, addr_nx;
    logic [CW-1:0] cnt;
    logic [BW-1:0] blk_left, l_blen;
    logic          l_blk, l_word;
    logic [3:0]    l_fac;
    logic [1:0]    l_ctl;
    logic          trig, is_steal, is_burst, is_rsvd;

    dma_trig_sel #(.NPER(NPER)) u_trig (
        .clk        (clk),
        .rst_n      (rst_n),
        .dreq_n     (dreq_n),
        .periph_req (periph_req),
        .blk_mode   (l_blk),
        .factor     (l_fac),
        .arm        (arm),
        .take       (take),
        .trig       (trig),
        .is_steal   (is_steal),
        .is_burst   (is_burst),
        .is_rsvd    (is_rsvd)
    );

    dma_addr_step #(.AW(AW)) u_step (
        .cur  (addr),
        .ctl  (l_ctl),
        .word (l_word),
        .nxt  (addr_nx)
    );

    assign arm  = (state == ST_IDLE) && en && !en_q && (xfer_count != '0);
    assign take = (state == ST_WAIT) && en && trig;
    assign last = (cnt == CW'(1));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (arm) state_nx = ST_WAIT;
            ST_WAIT: begin
                if (!en)       state_nx = ST_IDLE;
                else if (trig) state_nx = ST_XFER;
            end
            ST_XFER: begin
                if (last)                  state_nx = ST_FIN;
                else if (blk_left > BW'(1)) state_nx = ST_XFER;
                else if (is_burst)         state_nx = ST_XFER;
                else if (is_steal)         state_nx = ST_GAP;
                else                       state_nx = ST_WAIT;
            end
            ST_GAP:  state_nx = ST_XFER;
            ST_FIN:  state_nx = ST_IDLE;
            default: state_nx = ST_IDLE;
        endcase
    end

    // channel registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q     <= 1'b0;
            addr     <= '0;
            cnt      <= '0;
            blk_left <= '0;
            l_blen   <= '0;
            l_blk    <= 1'b0;
            l_word   <= 1'b0;
            l_fac    <= '0;
            l_ctl    <= '0;
        end else begin
            en_q <= en;
            if (arm) begin
                addr     <= start_addr;
                cnt      <= xfer_count;
                blk_left <= BW'(1);
                l_blen   <= blk_len;
                l_blk    <= blk_mode;
                l_word   <= word_size;
                l_fac    <= factor;
                l_ctl    <= dst_ctl;
            end
            if (take)
                blk_left <= (l_blk && l_blen != '0) ? l_blen : BW'(1);
            if (state == ST_XFER) begin
                addr <= addr_nx;
                cnt  <= cnt - CW'(1);
                if (blk_left > BW'(1)) blk_left <= blk_left - BW'(1);
            end
        end
    end

    // outputs
    always_comb begin
        xfer_stb  = (state == ST_XFER);
        busy      = (state == ST_WAIT) || (state == ST_XFER) || (state == ST_GAP);
        done      = (state == ST_FIN);
        dst_addr  = addr;
        xfer_word = l_word;
    end

    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !busy));

    assert_fixed_addr_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_stb && !l_ctl[1]) |=> (dst_addr == $past(dst_addr)));

    assert_inc_byte_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_stb && l_ctl == 2'b10 && !l_word) |=> (dst_addr == $past(dst_addr) + AW'(1)));

    assert_steal_gap_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_stb && is_steal && !last) |=> !xfer_stb);

    assert_burst_run_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_stb && is_burst && !last) |=> xfer_stb);

    assert_rsvd_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && is_rsvd) |-> !xfer_stb);

endmodule

// File: tb/test_dma_chan_ctrl.sv
`timescale 1ns/1ps
module test_dma_chan_ctrl;
    localparam int AW = 24, CW = 16, BW = 8, NP = 11;

    logic clk, rst_n, en, blk_mode, word_size, dreq_n;
    logic [3:0] factor;
    logic [1:0] dst_ctl;
    logic [AW-1:0] start_addr;
    logic [CW-1:0] xfer_count;
    logic [BW-1:0] blk_len;
    logic [NP-1:0] periph_req;
    logic xfer_stb, xfer_word, busy, done;
    logic [AW-1:0] dst_addr;

    int total = 0, bad = 0, cyc = 0;
    int stb_cnt = 0, run = 0, maxrun = 0, done_cnt = 0;

    dma_chan_ctrl i_dma_chan_ctrl (
        .clk(clk), .rst_n(rst_n), .en(en), .blk_mode(blk_mode), .factor(factor),
        .word_size(word_size), .dst_ctl(dst_ctl), .start_addr(start_addr),
        .xfer_count(xfer_count), .blk_len(blk_len), .dreq_n(dreq_n),
        .periph_req(periph_req), .xfer_stb(xfer_stb), .xfer_word(xfer_word),
        .dst_addr(dst_addr), .busy(busy), .done(done)
    );

    initial clk = 1'b0;
    always #2.5 clk = ~clk;

    // behavioural reference model (states: 0 idle,1 wait,2 xfer,3 gap,4 fin)
    bit ms1 = 1, ms2 = 1, ms3 = 1, mpend = 0, men_q = 0, mblk = 0, mword = 0;
    int mst = 0, mcnt = 0, mbl = 0, mblen = 0;
    logic [AW-1:0] maddr = '0;
    logic [3:0] mfac = '0;
    logic [1:0] mctl = '0;

    function automatic bit m_trig();
        bit f;
        int c;
        f = ms3 && !ms2;
        c = int'(mfac);
        if (!mblk) begin
            if (c == 2) return f || mpend;
            if (c == 3) return !ms2;
            if (c == 6 || c == 7) return 1'b1;
            return 1'b0;
        end
        if (c == 1) return periph_req[0];
        if (c == 2) return f || mpend;
        if (c == 3) return !ms2;
        if (c >= 4 && c <= 13) return periph_req[c-3];
        return 1'b0;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ms1 = 1; ms2 = 1; ms3 = 1; mpend = 0; men_q = 0; mst = 0;
            maddr = '0; mcnt = 0; mbl = 0; mblk = 0; mword = 0; mfac = '0; mctl = '0; mblen = 0;
        end else begin
            bit t, f, a, k;
            int nst;
            t = m_trig();
            f = ms3 && !ms2;
            a = (mst == 0) && en && !men_q && (xfer_count != 0);
            k = (mst == 1) && en && t;
            nst = mst;
            case (mst)
                0: if (a) nst = 1;
                1: if (!en) nst = 0; else if (t) nst = 2;
                2: begin
                    if (mcnt == 1) nst = 4;
                    else if (mbl > 1) nst = 2;
                    else if (!mblk && mfac == 4'd7) nst = 2;
                    else if (!mblk && mfac == 4'd6) nst = 3;
                    else nst = 1;
                end
                3: nst = 2;
                default: nst = 0;
            endcase
            if (a) begin
                maddr = start_addr; mcnt = int'(xfer_count); mbl = 1; mblen = int'(blk_len);
                mblk = blk_mode; mword = word_size; mfac = factor; mctl = dst_ctl;
            end
            if (k) mbl = (mblk && mblen != 0) ? mblen : 1;
            if (mst == 2) begin
                if (mctl == 2'b10) maddr = maddr + (mword ? 24'd2 : 24'd1);
                else if (mctl == 2'b11) maddr = maddr - (mword ? 24'd2 : 24'd1);
                mcnt = mcnt - 1;
                if (mbl > 1) mbl = mbl - 1;
            end
            if (a) mpend = 0;
            else if (k) mpend = mpend && f;
            else mpend = mpend || f;
            ms3 = ms2; ms2 = ms1; ms1 = dreq_n; men_q = en; mst = nst;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // per-cycle comparison and strobe statistics
    always @(negedge clk) begin
        if (rst_n) begin
            chk("R9 busy vs model", 32'(busy), 32'(mst >= 1 && mst <= 3));
            chk("R9 done vs model", 32'(done), 32'(mst == 4));
            chk("R7 xfer_stb vs model", 32'(xfer_stb), 32'(mst == 2));
            chk("R3 dst_addr vs model", 32'(dst_addr), 32'(maddr));
            chk("R11 xfer_word vs model", 32'(xfer_word), 32'(mword));
            if (xfer_stb) begin
                stb_cnt++; run++;
                if (run > maxrun) maxrun = run;
            end else run = 0;
            if (done) done_cnt++;
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            bad++; total++;
            $display("FAIL watchdog actual=%0d expected<150000", cyc);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    task automatic clr_stats();
        stb_cnt = 0; maxrun = 0; done_cnt = 0;
    endtask

    task automatic arm_ch(input bit bm, input logic [3:0] fc, input bit w, input logic [1:0] dc,
                          input logic [AW-1:0] sa, input int cnt, input int bl);
        en = 0;
        blk_mode = bm; factor = fc; word_size = w; dst_ctl = dc;
        start_addr = sa; xfer_count = CW'(cnt); blk_len = BW'(bl);
        tick(2);
        clr_stats();
        en = 1;
        tick(1);
    endtask

    task automatic wait_done(input string tag);
        int n = 0;
        while (done_cnt == 0 && n < 2000) begin tick(1); n++; end
        chk(tag, 32'(done_cnt != 0), 32'd1);
        tick(1);
    endtask

    task automatic pulse(input int idx);
        periph_req[idx] = 1'b1;
        tick(1);
        periph_req[idx] = 1'b0;
    endtask

    initial begin
        rst_n = 0; en = 0; blk_mode = 0; factor = '0; word_size = 0; dst_ctl = '0;
        start_addr = '0; xfer_count = '0; blk_len = '0; dreq_n = 1; periph_req = '0;
        tick(3);
        chk("R1 reset busy", 32'(busy), 0);
        chk("R1 reset done", 32'(done), 0);
        chk("R1 reset xfer_stb", 32'(xfer_stb), 0);
        chk("R1 reset dst_addr", 32'(dst_addr), 0);
        rst_n = 1;
        tick(2);

        // R2: zero count never arms
        arm_ch(0, 4'b0111, 0, 2'b10, 24'h000055, 0, 0);
        tick(3);
        chk("R2 zero count stays idle", 32'(busy), 0);

        // R4 R7: burst, byte increment
        arm_ch(0, 4'b0111, 0, 2'b10, 24'h000010, 4, 0);
        wait_done("R9 burst completes");
        chk("R7 burst strobes", 32'(stb_cnt), 4);
        chk("R7 burst back to back", 32'(maxrun), 4);
        chk("R3 byte increment end", 32'(dst_addr), 32'h14);
        chk("R9 not busy after done", 32'(busy), 0);

        // R3: word decrement wraps
        arm_ch(0, 4'b0111, 1, 2'b11, 24'h000001, 3, 0);
        wait_done("R9 decrement completes");
        chk("R3 word decrement wraps", 32'(dst_addr), 32'hFFFFFB);

        // R3: fixed address
        arm_ch(0, 4'b0111, 1, 2'b01, 24'hABCDE0, 3, 0);
        wait_done("R9 fixed completes");
        chk("R3 fixed address", 32'(dst_addr), 32'hABCDE0);

        // R4 R7: cycle steal
        arm_ch(0, 4'b0110, 1, 2'b10, 24'h000100, 5, 0);
        wait_done("R7 steal completes");
        chk("R7 steal strobes", 32'(stb_cnt), 5);
        chk("R7 steal gaps", 32'(maxrun), 1);
        chk("R3 word increment end", 32'(dst_addr), 32'h10A);

        // R5: edge requests
        dreq_n = 1;
        arm_ch(0, 4'b0010, 0, 2'b10, 24'h000300, 3, 0);
        chk("R2 armed busy", 32'(busy), 1);
        chk("R2 armed address", 32'(dst_addr), 32'h300);
        tick(10);
        chk("R5 no edge no transfer", 32'(stb_cnt), 0);
        dreq_n = 0; tick(8);
        chk("R5 one edge one transfer", 32'(stb_cnt), 1);
        tick(10);
        chk("R5 held low no more", 32'(stb_cnt), 1);
        dreq_n = 1; tick(4); dreq_n = 0; tick(8);
        chk("R5 second edge", 32'(stb_cnt), 2);
        dreq_n = 1; tick(4); dreq_n = 0;
        wait_done("R5 edge run completes");
        chk("R5 total strobes", 32'(stb_cnt), 3);

        // R6: level requests, then R9 triggers ignored after done
        dreq_n = 1;
        arm_ch(0, 4'b0011, 0, 2'b10, 24'h000400, 4, 0);
        tick(5);
        chk("R6 high pin no transfer", 32'(stb_cnt), 0);
        dreq_n = 0;
        wait_done("R6 level completes");
        chk("R6 level strobes", 32'(stb_cnt), 4);
        chk("R6 level one per wait", 32'(maxrun), 1);
        tick(10);
        chk("R9 ignored after done", 32'(stb_cnt), 4);
        chk("R9 idle after done", 32'(busy), 0);
        dreq_n = 1;

        // R8: block mode, timer 2 capture line (code 1010, line 7)
        arm_ch(1, 4'b1010, 0, 2'b10, 24'h000200, 6, 3);
        tick(5);
        chk("R8 no request no block", 32'(stb_cnt), 0);
        pulse(7); tick(8);
        chk("R8 one block", 32'(stb_cnt), 3);
        chk("R8 block back to back", 32'(maxrun), 3);
        pulse(6); tick(8);
        chk("R8 other line ignored", 32'(stb_cnt), 3);
        pulse(7);
        wait_done("R8 second block completes");
        chk("R8 block total", 32'(stb_cnt), 6);
        chk("R8 block address", 32'(dst_addr), 32'h206);

        // R8: ADC end line
        arm_ch(1, 4'b0001, 0, 2'b10, 24'h000000, 2, 2);
        tick(3);
        pulse(0);
        wait_done("R8 adc block completes");
        chk("R8 adc strobes", 32'(stb_cnt), 2);

        // R8 R9: count ends mid-block in block level mode
        arm_ch(1, 4'b0011, 0, 2'b10, 24'h000500, 4, 3);
        dreq_n = 0;
        wait_done("R9 mid-block end completes");
        chk("R9 mid-block strobes", 32'(stb_cnt), 4);
        chk("R8 mid-block run", 32'(maxrun), 3);
        dreq_n = 1;

        // R10: reserved codes, abort
        dreq_n = 0; periph_req = '1;
        arm_ch(0, 4'b0001, 0, 2'b10, 24'h000600, 3, 0);
        tick(20);
        chk("R10 normal reserved no strobe", 32'(stb_cnt), 0);
        chk("R10 reserved stays busy", 32'(busy), 1);
        en = 0; tick(3);
        chk("R10 abort to idle", 32'(busy), 0);
        chk("R10 abort no done", 32'(done_cnt), 0);
        arm_ch(1, 4'b1110, 0, 2'b10, 24'h000600, 3, 2);
        tick(20);
        chk("R10 block reserved no strobe", 32'(stb_cnt), 0);
        en = 0; tick(3);
        dreq_n = 1; periph_req = '0;
        tick(5);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule